// File: doc/BRIEF.md
# Dual-Link SATA Register Merger

This block sits in front of one virtual SATA port that is really two physical links, a master and a slave. Host software sees a single set of status, error and control registers. Each host request is turned into downstream accesses on an index/data register window. Every access writes a selector word to the index register and then reads or writes the data register. A read can collect one value from each link, and the two values are folded into one 32-bit word.

The folding rule depends on the register. The error register is the bitwise OR of both links. Status and control are combined one 4-bit field at a time. When the two fields are equal, that value is kept. When they differ, a fixed precedence list is searched and its first entry that matches either field wins. If no entry matches, the last entry of the list wins. Fields that have no list take the master's value.

A write is copied to the master and then to the slave. When the slave-possible configuration bit is clear, only the master is touched. The host holds `req_valid` until it sees the one-cycle `req_ack` pulse, and then drops it. Only one request is in flight at a time.

Top module: `sata_reg_merge`

## Requirements
- R1: Host code 3 is not a register. A request with code 3, read or write, ends with `req_ack` and `req_err` both high and `req_rdata` zero, and no downstream strobe is issued.
- R2: Every downstream access writes the index register at offset 0 with `((port*2 + dev) << 8) | link_code` and then accesses the data register at offset 4. Link code 0 is status, 1 is control and 2 is error. Host code 0 is status, 1 is error and 2 is control.
- R3: With `cfg_slave_ok` low, a read returns device 0's raw value, and a write reaches device 0 only. Exactly one index write and one data access take place.
- R4: With `cfg_slave_ok` high, both devices are accessed, device 0 first. A write stores the same value in both links.
- R5: With `cfg_slave_ok` high, an error read returns device 0 OR device 1.
- R6: With `cfg_slave_ok` high, a status read merges field by field. Field 0 (bits 3:0) uses the list 1,3,0,4,3. Field 1 uses 2,1,0. Field 2 uses 6,2,1,0. Bits 31:12 come from device 0. Equal fields pass through, the first list entry that matches either field wins, and with no match the last entry is used.
- R7: With `cfg_slave_ok` high, a control read merges by the same rule. Field 0 uses 1,0,4,0. Field 1 uses 0,2,1,0. Field 2 uses 0,1,2,3,0. Bits 31:12 come from device 0.
- R8: Each downstream strobe lasts one cycle, and the block waits for `dn_rdy` before the next step. `req_ack` is a single-cycle pulse issued only after the last downstream access has completed.
- R9: After reset, `req_ack`, `req_err` and `dn_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave_ok | input | 1 | Slave link present; sampled when a request is accepted |
| cfg_port | input | PORT_W | Virtual port number used in the index word |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 2 | Host register code: 0 status, 1 error, 2 control |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request rejected, valid with req_ack |
| req_rdata | output | DATA_W | Read result, valid with req_ack |
| dn_stb | output | 1 | Downstream access strobe, one cycle |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | ADDR_W | Downstream byte offset (0 index, 4 data) |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdy | input | 1 | Downstream access complete |
| dn_rdata | input | DATA_W | Downstream read data, valid with dn_rdy |

## Verification
A wrong device counter or state shows up in the logged index words and data-write order of the very request it corrupts. It also shows as a data-completion count that differs at the acknowledge. A wrong precedence entry or list length shows only when the two link fields differ in a way that reaches that entry. For that reason the status and control merges are driven with directed corner pairs and with many pseudo-random pairs whose field values are limited to 0 through 7. The merged word is then compared at the acknowledge of that same read.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    HC_STATUS  = 2'd0,
    HC_ERROR   = 2'd1,
    HC_CONTROL = 2'd2,
    HC_BAD     = 2'd3
  } host_code_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_IDX_STB,
    S_IDX_WAIT,
    S_DAT_STB,
    S_DAT_WAIT,
    S_RESP
  } seq_state_e;

  localparam int FIELD_W  = 4;
  localparam int LIST_MAX = 5;

  // register code as seen by the link window
  function automatic logic [7:0] link_code(host_code_e c);
    case (c)
      HC_STATUS:  return 8'd0;
      HC_CONTROL: return 8'd1;
      HC_ERROR:   return 8'd2;
      default:    return 8'd0;
    endcase
  endfunction

  // packed precedence lists, entry 0 in the low nibble
  function automatic logic [LIST_MAX*FIELD_W-1:0] prec_pack(bit ctrl, int field);
    if (!ctrl) begin
      case (field)
        0:       return 20'h34031;
        1:       return 20'h00012;
        2:       return 20'h00126;
        default: return '0;
      endcase
    end else begin
      case (field)
        0:       return 20'h00401;
        1:       return 20'h00120;
        2:       return 20'h03210;
        default: return '0;
      endcase
    end
  endfunction

  function automatic int prec_len(bit ctrl, int field);
    if (!ctrl) begin
      case (field)
        0:       return 5;
        1:       return 3;
        2:       return 4;
        default: return 0;
      endcase
    end else begin
      case (field)
        0:       return 4;
        1:       return 4;
        2:       return 5;
        default: return 0;
      endcase
    end
  endfunction

  function automatic logic [FIELD_W-1:0] prec_item(bit ctrl, int field, int idx);
    logic [LIST_MAX*FIELD_W-1:0] lst;
    lst = prec_pack(ctrl, field);
    if (idx < 0 || idx >= LIST_MAX) return '0;
    return lst[idx*FIELD_W +: FIELD_W];
  endfunction

endpackage

// File: rtl/srm_field_merge.sv
module srm_field_merge
  import srm_pkg::*;
#(
  parameter bit CTRL  = 1'b0,
  parameter int FIELD = 0
) (
  input  logic [FIELD_W-1:0] c0,
  input  logic [FIELD_W-1:0] c1,
  output logic [FIELD_W-1:0] m
);

  localparam int LEN = prec_len(CTRL, FIELD);

  logic [FIELD_W-1:0] pick;

  always_comb begin
    pick = prec_item(CTRL, FIELD, LEN - 1);
    // scan from the tail so the earliest match is left in pick
    for (int i = LEN - 1; i >= 0; i--) begin
      if (prec_item(CTRL, FIELD, i) == c0 || prec_item(CTRL, FIELD, i) == c1)
        pick = prec_item(CTRL, FIELD, i);
    end
    if (LEN == 0 || c0 == c1) m = c0;
    else                      m = pick;
  end

endmodule

// File: rtl/srm_word_merge.sv
module srm_word_merge
  import srm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit CTRL   = 1'b0
) (
  input  logic [DATA_W-1:0] v0,
  input  logic [DATA_W-1:0] v1,
  output logic [DATA_W-1:0] m
);

  localparam int FIELDS = DATA_W / FIELD_W;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    srm_field_merge #(.CTRL(CTRL), .FIELD(g)) u_fm (
      .c0 (v0[g*FIELD_W +: FIELD_W]),
      .c1 (v1[g*FIELD_W +: FIELD_W]),
      .m  (m[g*FIELD_W +: FIELD_W])
    );
  end

endmodule

// File: rtl/srm_link_seq.sv
module srm_link_seq
  import srm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bad,
  input  logic              write,
  input  logic              two_dev,
  input  logic [PORT_W-1:0] port,
  input  logic [7:0]        lcode,
  input  logic [DATA_W-1:0] wdata,
  output logic              dn_stb,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rdy,
  output logic              cap_en,
  output logic              cap_dev,
  output logic              done
);

  localparam int SEL_W = PORT_W + 1;
  localparam logic [ADDR_W-1:0] IDX_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DAT_OFF = ADDR_W'(4);

  seq_state_e state_q, state_nx;
  logic       dev_q, dev_nx;
  logic [DATA_W-1:0] idx_word;

  always_comb begin
    idx_word = '0;
    idx_word[8 +: SEL_W] = {port, dev_q};
    idx_word[7:0] = lcode;
  end

  always_comb begin
    state_nx = state_q;
    dev_nx   = dev_q;
    dn_stb   = 1'b0;
    dn_we    = 1'b0;
    dn_addr  = IDX_OFF;
    dn_wdata = '0;
    cap_en   = 1'b0;
    cap_dev  = dev_q;
    done     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          dev_nx   = 1'b0;
          state_nx = bad ? S_RESP : S_IDX_STB;
        end
      end
      S_IDX_STB: begin
        dn_stb   = 1'b1;
        dn_we    = 1'b1;
        dn_addr  = IDX_OFF;
        dn_wdata = idx_word;
        state_nx = S_IDX_WAIT;
      end
      S_IDX_WAIT: begin
        if (dn_rdy) state_nx = S_DAT_STB;
      end
      S_DAT_STB: begin
        dn_stb   = 1'b1;
        dn_we    = write;
        dn_addr  = DAT_OFF;
        dn_wdata = write ? wdata : '0;
        state_nx = S_DAT_WAIT;
      end
      S_DAT_WAIT: begin
        if (dn_rdy) begin
          cap_en = !write;
          if (two_dev && !dev_q) begin
            dev_nx   = 1'b1;
            state_nx = S_IDX_STB;
          end else begin
            state_nx = S_RESP;
          end
        end
      end
      S_RESP: begin
        done     = 1'b1;
        state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dev_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      dev_q   <= dev_nx;
    end
  end

  // R8: a strobe never spans two cycles
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb |=> !dn_stb);

  // R2: index register accesses are always writes
  assert_index_is_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stb && dn_addr == IDX_OFF) |-> dn_we);

  // R2: the data access comes one wait phase after an index write
  assert_data_after_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stb && dn_addr == DAT_OFF) |-> $past(state_q) == S_IDX_WAIT);

  // R8: no progress past a data access until ready
  assert_wait_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DAT_WAIT && !dn_rdy) |=> state_q == S_DAT_WAIT);

endmodule

// File: rtl/sata_reg_merge.sv
module sata_reg_merge
  import srm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slave_ok,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_code,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic              req_err,
  output logic [DATA_W-1:0] req_rdata,
  output logic              dn_stb,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rdy,
  input  logic [DATA_W-1:0] dn_rdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic              busy_q, busy_nx, go_q, accept;
  host_code_e        code_q;
  logic              write_q, two_q, bad_q;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] v0_q, v1_q, m_st, m_ct, res;
  logic              cap_en, cap_dev, done;
  logic [2:0]        stb_cnt_q, stb_cnt_nx;

  assign accept = req_valid && !busy_q;

  always_comb begin
    busy_nx = busy_q;
    if (accept)    busy_nx = 1'b1;
    else if (done) busy_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      busy_q <= busy_nx;
      go_q   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      code_q  <= HC_STATUS;
      write_q <= 1'b0;
      two_q   <= 1'b0;
      bad_q   <= 1'b0;
      port_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      code_q  <= host_code_e'(req_code);
      write_q <= req_write;
      two_q   <= cfg_slave_ok;
      bad_q   <= (req_code == HC_BAD);
      port_q  <= cfg_port;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      v0_q <= '0;
      v1_q <= '0;
    end else if (cap_en) begin
      if (cap_dev) v1_q <= dn_rdata;
      else         v0_q <= dn_rdata;
    end
  end

  srm_link_seq #(.DATA_W(DATA_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (go_q),
    .bad      (bad_q),
    .write    (write_q),
    .two_dev  (two_q),
    .port     (port_q),
    .lcode    (link_code(code_q)),
    .wdata    (wdata_q),
    .dn_stb   (dn_stb),
    .dn_we    (dn_we),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_rdy   (dn_rdy),
    .cap_en   (cap_en),
    .cap_dev  (cap_dev),
    .done     (done)
  );

  srm_word_merge #(.DATA_W(DATA_W), .CTRL(1'b0)) u_merge_status (
    .v0 (v0_q), .v1 (v1_q), .m (m_st)
  );

  srm_word_merge #(.DATA_W(DATA_W), .CTRL(1'b1)) u_merge_control (
    .v0 (v0_q), .v1 (v1_q), .m (m_ct)
  );

  always_comb begin
    res = '0;
    if (!write_q && !bad_q) begin
      if (!two_q) res = v0_q;
      else begin
        case (code_q)
          HC_STATUS:  res = m_st;
          HC_CONTROL: res = m_ct;
          HC_ERROR:   res = v0_q | v1_q;
          default:    res = '0;
        endcase
      end
    end
  end

  assign req_ack   = done;
  assign req_err   = done && bad_q;
  assign req_rdata = done ? res : '0;

  // strobe count per request, used only by the checks below
  always_comb begin
    stb_cnt_nx = stb_cnt_q;
    if (go_q)        stb_cnt_nx = '0;
    else if (dn_stb) stb_cnt_nx = stb_cnt_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) stb_cnt_q <= '0;
    else          stb_cnt_q <= stb_cnt_nx;
  end

  // R1: a rejected request leaves the link window untouched
  assert_bad_code_no_access_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_ack && req_err) |-> stb_cnt_q == 3'd0);

  // R3 / R4: two or four strobes depending on slave presence
  assert_access_count_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_ack && !req_err) |-> stb_cnt_q == (two_q ? 3'd4 : 3'd2));

  // R3: single-device read is passed through
  assert_single_dev_pass_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_ack && !req_err && !two_q && !write_q) |-> req_rdata == v0_q);

  // R6: status fields without a list follow device 0
  assert_status_upper_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_ack && two_q && !write_q && code_q == HC_STATUS)
      |-> req_rdata[DATA_W-1:12] == v0_q[DATA_W-1:12]);

  // R5: error result has no bit that neither link reported
  assert_error_or_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_ack && two_q && !write_q && code_q == HC_ERROR)
      |-> (req_rdata & ~(v0_q | v1_q)) == '0);

  // R8: acknowledge is a single pulse
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ack |=> !req_ack);

endmodule

// File: tb/test_sata_reg_merge.sv
module test_sata_reg_merge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_slave_ok;
  logic [1:0]  cfg_port;
  logic        req_valid, req_write;
  logic [1:0]  req_code;
  logic [31:0] req_wdata;
  logic        req_ack, req_err;
  logic [31:0] req_rdata;
  logic        dn_stb, dn_we;
  logic [3:0]  dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_rdy;
  logic [31:0] dn_rdata;

  always #2 clk = ~clk;

  sata_reg_merge i_sata_reg_merge (
    .clk, .rst_n, .cfg_slave_ok, .cfg_port, .req_valid, .req_write, .req_code,
    .req_wdata, .req_ack, .req_err, .req_rdata, .dn_stb, .dn_we, .dn_addr,
    .dn_wdata, .dn_rdy, .dn_rdata
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // ---------------- link model: two devices per port, 8 selectors ----------
  logic [31:0] lmem [0:7][0:2];
  logic [15:0] lidx;
  bit          pend;
  int          lat_cnt, lat_seed;
  logic        p_we;
  logic [3:0]  p_addr;
  logic [31:0] p_wdata;
  int          idx_log[$];
  int          wr_log[$];
  int          dat_cnt;
  bit          outstanding;
  bit          cur_bad;

  always @(negedge clk) begin
    if (!rst_n) begin
      dn_rdy = 1'b0; dn_rdata = '0; pend = 0; lat_seed = 0;
    end else begin
      // per-clock port checks against the bench's request state
      if (req_ack && !outstanding) chk(0, "R8", "ack without request", 1, 0);
      if (dn_stb && (!outstanding || cur_bad)) chk(0, "R1", "strobe without valid request", 1, 0);
      dn_rdy = 1'b0;
      if (pend) begin
        if (lat_cnt == 0) begin
          dn_rdy = 1'b1;
          pend = 0;
          if (p_addr == 4'd0) begin
            lidx = p_wdata[15:0];
            idx_log.push_back(int'(p_wdata));
          end else if (p_addr == 4'd4 && lidx[1:0] != 2'd3) begin
            dat_cnt++;
            if (p_we) begin
              lmem[lidx[10:8]][lidx[1:0]] = p_wdata;
              wr_log.push_back(int'(lidx[10:8]));
            end else begin
              dn_rdata = lmem[lidx[10:8]][lidx[1:0]];
            end
          end
        end else lat_cnt--;
      end
      if (dn_stb) begin
        pend = 1; p_we = dn_we; p_addr = dn_addr; p_wdata = dn_wdata;
        lat_cnt = lat_seed % 3; lat_seed++;
      end
    end
  end

  // ---------------- reference merge -----------------------------------------
  function automatic logic [31:0] ref_merge(logic [31:0] a, logic [31:0] b, bit ctrl);
    logic [31:0] r = '0;
    for (int n = 0; n < 8; n++) begin
      int lst[$];
      int ca = int'(a[n*4 +: 4]);
      int cb = int'(b[n*4 +: 4]);
      int pick;
      lst = {};
      if (!ctrl) begin
        if (n == 0) lst = '{1, 3, 0, 4, 3};
        if (n == 1) lst = '{2, 1, 0};
        if (n == 2) lst = '{6, 2, 1, 0};
      end else begin
        if (n == 0) lst = '{1, 0, 4, 0};
        if (n == 1) lst = '{0, 2, 1, 0};
        if (n == 2) lst = '{0, 1, 2, 3, 0};
      end
      if (lst.size() == 0 || ca == cb) pick = ca;
      else begin
        pick = lst[lst.size() - 1];
        for (int k = lst.size() - 1; k >= 0; k--)
          if (lst[k] == ca || lst[k] == cb) pick = lst[k];
      end
      r[n*4 +: 4] = 4'(pick);
    end
    return r;
  endfunction

  function automatic int lcode_of(logic [1:0] hc);
    return (hc == 2'd0) ? 0 : (hc == 2'd1) ? 2 : 1;
  endfunction

  // ---------------- host transaction -----------------------------------------
  task automatic xact(input bit wr, input logic [1:0] code, input logic [31:0] wd,
                      input bit slv, input logic [1:0] port,
                      output logic [31:0] rd, output bit er);
    int exp_dat;
    @(negedge clk);
    idx_log = {}; wr_log = {}; dat_cnt = 0;
    cfg_slave_ok = slv; cfg_port = port;
    req_write = wr; req_code = code; req_wdata = wd;
    cur_bad = (code == 2'd3);
    outstanding = 1; req_valid = 1'b1;
    do @(negedge clk); while (!req_ack);
    rd = req_rdata; er = req_err;
    exp_dat = cur_bad ? 0 : (slv ? 2 : 1);
    chk(dat_cnt == exp_dat && !pend, "R8", "ack before sequence end", dat_cnt, exp_dat);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ack, "R8", "ack longer than one cycle", req_ack, 0);
    outstanding = 0;
  endtask

  task automatic merged_read(logic [1:0] code, logic [31:0] a, logic [31:0] b, string req);
    logic [31:0] rd, exp;
    bit er;
    int lc = lcode_of(code);
    lmem[0][lc] = a; lmem[1][lc] = b;
    xact(0, code, '0, 1, 2'd0, rd, er);
    if (code == 2'd1)      exp = a | b;
    else if (code == 2'd0) exp = ref_merge(a, b, 0);
    else                   exp = ref_merge(a, b, 1);
    chk(rd == exp && !er, req, "merged read", rd, exp);
  endtask

  initial begin
    logic [31:0] rd, lfsr, a, b, keep;
    bit er;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_code = 0; req_wdata = 0;
    cfg_slave_ok = 0; cfg_port = 0; outstanding = 0; cur_bad = 0;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 3; c++) lmem[s][c] = 32'h1000_0000 * s + 32'h0111 * c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk(!req_ack && !req_err && !dn_stb, "R9", "idle outputs after reset",
        {29'd0, req_ack, req_err, dn_stb}, 0);

    // R1 bad code, read and write
    xact(0, 2'd3, '0, 1, 2'd1, rd, er);
    chk(er && rd == 0 && idx_log.size() == 0, "R1", "bad read rejected", {31'd0, er}, 1);
    keep = lmem[2][0];
    xact(1, 2'd3, 32'hDEAD_BEEF, 1, 2'd1, rd, er);
    chk(er && wr_log.size() == 0 && idx_log.size() == 0, "R1", "bad write rejected", {31'd0, er}, 1);
    chk(lmem[2][0] == keep && lmem[3][0] != 32'hDEAD_BEEF, "R1", "links unchanged", lmem[2][0], keep);

    // R2 index words and ordering
    xact(0, 2'd0, '0, 1, 2'd2, rd, er);
    chk(idx_log.size() == 2 && idx_log[0] == 32'h400 && idx_log[1] == 32'h500,
        "R2", "status index words", idx_log.size() > 1 ? idx_log[1] : 0, 32'h500);
    xact(0, 2'd2, '0, 1, 2'd1, rd, er);
    chk(idx_log.size() == 2 && idx_log[0] == 32'h201 && idx_log[1] == 32'h301,
        "R2", "control index words", idx_log.size() > 0 ? idx_log[0] : 0, 32'h201);
    xact(0, 2'd1, '0, 1, 2'd3, rd, er);
    chk(idx_log.size() == 2 && idx_log[0] == 32'h602 && idx_log[1] == 32'h702,
        "R2", "error index words", idx_log.size() > 0 ? idx_log[0] : 0, 32'h602);

    // R3 slave absent
    lmem[2][0] = 32'h0000_0203; lmem[3][0] = 32'h0000_0113;
    xact(0, 2'd0, '0, 0, 2'd1, rd, er);
    chk(rd == 32'h0000_0203 && idx_log.size() == 1, "R3", "single read passthrough", rd, 32'h0000_0203);
    keep = lmem[3][1];
    xact(1, 2'd2, 32'h0000_0301, 0, 2'd1, rd, er);
    chk(wr_log.size() == 1 && wr_log[0] == 2, "R3", "write reaches dev0 only", wr_log.size(), 1);
    chk(lmem[2][1] == 32'h0000_0301 && lmem[3][1] == keep, "R3", "dev1 untouched", lmem[3][1], keep);

    // R4 slave present: write order and contents
    xact(1, 2'd2, 32'h0000_0004, 1, 2'd0, rd, er);
    chk(wr_log.size() == 2 && wr_log[0] == 0 && wr_log[1] == 1, "R4", "write order dev0 then dev1",
        wr_log.size(), 2);
    chk(lmem[0][1] == 32'h4 && lmem[1][1] == 32'h4, "R4", "both links written", lmem[1][1], 32'h4);
    xact(1, 2'd1, 32'hFFFF_FFFF, 1, 2'd3, rd, er);
    chk(lmem[6][2] == 32'hFFFF_FFFF && lmem[7][2] == 32'hFFFF_FFFF, "R4", "error write both",
        lmem[7][2], 32'hFFFF_FFFF);

    // R5 error OR
    merged_read(2'd1, 32'h0000_0F01, 32'h0010_0002, "R5");
    merged_read(2'd1, 32'h8000_0000, 32'h0000_0001, "R5");

    // R6 status corners
    merged_read(2'd0, 32'h0000_0123, 32'h0000_0123, "R6");
    merged_read(2'd0, 32'h0000_0004, 32'h0000_0000, "R6");
    merged_read(2'd0, 32'h0000_0002, 32'h0000_0005, "R6");
    merged_read(2'd0, 32'h0000_0613, 32'h0000_0023, "R6");
    merged_read(2'd0, 32'hABCD_E000, 32'h1234_5000, "R6");

    // R7 control corners
    merged_read(2'd2, 32'h0000_0004, 32'h0000_0001, "R7");
    merged_read(2'd2, 32'h0000_0053, 32'h0000_0072, "R7");
    merged_read(2'd2, 32'h0000_0744, 32'h0000_0533, "R7");
    merged_read(2'd2, 32'h5555_5000, 32'h0000_0000, "R7");

    // R6 / R7 pseudo-random fields in 0..7
    lfsr = 32'hACE1_2345;
    for (int t = 0; t < 24; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr & 32'h7777_7777;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr & 32'h7777_7777;
      merged_read(2'd0, a, b, "R6");
      merged_read(2'd2, b, a, "R7");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL R8 watchdog expired: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule